// File: doc/BRIEF.md
# SMRAM Window Control with Lock

This block holds two byte-wide configuration registers that govern the legacy system-management RAM window. These are a main control byte and an extended control byte. It also decides, for each memory access, whether that access lands in RAM or goes down the default path. The main byte carries four control flags: open, close, lock and global enable. It also has a base-segment field that is fixed at 010. The extended byte exposes four writable bits. Its remaining bits are fixed at their reset values.

Setting the lock flag narrows what software can change in both registers together. Once locked, the close flag is the only writable bit left in the main byte, and no bit of the extended byte can be written. Only reset clears the lock.

The access-side decision uses the current register state together with a flag that marks accesses made in system-management context. It is purely combinational.

Top module: `smram_lock_ctrl`

## Requirements
- R1: After reset the main byte (offset 0x9d) reads 0x02, the extended byte (offset 0x9e) reads 0x38, and the lock is clear.
- R2: While unlocked, a write to the main byte changes only bits 6 (open), 5 (close), 4 (lock) and 3 (global enable). Bits 2:0 always read 010 and bit 7 always reads 0.
- R3: While unlocked, a write to the extended byte changes only bits 7, 2, 1 and 0. Bit 6 always reads 0 and bits 5:3 always read 1.
- R4: Writing the main byte with bit 4 set engages the lock. Once engaged, the lock stays set until reset.
- R5: While locked, a write to the main byte changes only bit 5 (close).
- R6: While locked, a write to the extended byte changes nothing.
- R7: A read at any offset other than 0x9d or 0x9e returns 0, and a write there leaves both registers unchanged.
- R8: An access counts as inside the compatible window when its address is at least 0xa0000 and below 0xc0000.
- R9: An access goes to RAM exactly when it lies inside the window, global enable is set, and either open is set or the access is in system-management context with close clear. Every other access takes the default path.
- R10: A write takes effect at the clock edge on which it is presented. Read data and the routing decision follow the register state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| mem_addr | input | 20 | Memory access address |
| mem_smm | input | 1 | Access made in system-management context |
| mem_in_compat | output | 1 | Address falls in the compatible window |
| mem_to_ram | output | 1 | Access routed to RAM |
| smram_ctl | output | 8 | Current main control byte |
| smram_ext | output | 8 | Current extended control byte |

## Verification
A write presented in one cycle appears in the register one clock edge later. The bench therefore holds each write strobe for exactly one cycle, starting from a falling edge, and reads back only after the next falling edge. Read data and routing carry no register stage. The bench changes the address or context inputs and samples a short delay later, within the same low phase. Writes are swept over every data value in both the unlocked and locked states, and the expected bytes are computed from the masks. Routing is checked for every flag combination at the window edges and just outside them.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned MEM_AW = 20;

  localparam logic [CFG_AW-1:0] OFS_CTL = 8'h9d;
  localparam logic [CFG_AW-1:0] OFS_EXT = 8'h9e;

  localparam int unsigned POS_OPEN  = 6;
  localparam int unsigned POS_CLOSE = 5;
  localparam int unsigned POS_LOCK  = 4;
  localparam int unsigned POS_GEN   = 3;

  localparam logic [REG_W-1:0] CTL_RST     = 8'h02;
  localparam logic [REG_W-1:0] CTL_WM_FREE = 8'h78;
  localparam logic [REG_W-1:0] CTL_WM_LOCK = 8'h20;
  localparam logic [REG_W-1:0] EXT_RST     = 8'h38;
  localparam logic [REG_W-1:0] EXT_WM_FREE = 8'h87;
  localparam logic [REG_W-1:0] EXT_WM_LOCK = 8'h00;

  localparam logic [MEM_AW-1:0] WIN_LO = 20'ha0000;
  localparam logic [MEM_AW-1:0] WIN_HI = 20'hc0000;
endpackage

// File: rtl/smram_mask_reg.sv
module smram_mask_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WM_FREE = '1,
  parameter logic [W-1:0] WM_LOCK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] wmask;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    wmask = lock_i ? WM_LOCK : WM_FREE;
    q_en  = wr_i;
    q_d   = (q_o & ~wmask) | (wdata_i & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (q_en) q_o <= q_d;
  end

  AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> ((q_o & ~WM_LOCK) == ($past(q_o) & ~WM_LOCK))); // R5, R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/smram_compat_decode.sv
module smram_compat_decode #(
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] LO = '0,
  parameter logic [AW-1:0] HI = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          smm_i,
  input  logic          open_i,
  input  logic          close_i,
  input  logic          gen_i,
  output logic          in_win_o,
  output logic          to_ram_o
);
  logic smm_view;

  always_comb begin
    in_win_o = (addr_i >= LO) && (addr_i < HI);
    smm_view = smm_i && !close_i;
    to_ram_o = in_win_o && gen_i && (smm_view || open_i);
  end

  AST_RAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    to_ram_o |-> in_win_o); // R8
  AST_RAM_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    to_ram_o |-> gen_i); // R9
endmodule

// File: rtl/smram_lock_ctrl.sv
module smram_lock_ctrl
  import smram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_smm,
  output logic              mem_in_compat,
  output logic              mem_to_ram,
  output logic [REG_W-1:0]  smram_ctl,
  output logic [REG_W-1:0]  smram_ext
);
  localparam int unsigned NREG = 2;

  logic [NREG-1:0] sel;
  logic [REG_W-1:0] regq [NREG];
  logic lock;

  always_comb begin
    sel[0] = cfg_wr && (cfg_addr == OFS_CTL);
    sel[1] = cfg_wr && (cfg_addr == OFS_EXT);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    smram_mask_reg #(
      .W(REG_W),
      .RST_VAL((g == 0) ? CTL_RST : EXT_RST),
      .WM_FREE((g == 0) ? CTL_WM_FREE : EXT_WM_FREE),
      .WM_LOCK((g == 0) ? CTL_WM_LOCK : EXT_WM_LOCK)
    ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_i(sel[g]), .lock_i(lock),
      .wdata_i(cfg_wdata), .q_o(regq[g])
    );
  end

  always_comb begin
    smram_ctl = regq[0];
    smram_ext = regq[1];
    lock      = smram_ctl[POS_LOCK];
    if (cfg_addr == OFS_CTL)      cfg_rdata = smram_ctl;
    else if (cfg_addr == OFS_EXT) cfg_rdata = smram_ext;
    else                          cfg_rdata = '0;
  end

  smram_compat_decode #(.AW(MEM_AW), .LO(WIN_LO), .HI(WIN_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr_i(mem_addr), .smm_i(mem_smm),
    .open_i(smram_ctl[POS_OPEN]), .close_i(smram_ctl[POS_CLOSE]),
    .gen_i(smram_ctl[POS_GEN]), .in_win_o(mem_in_compat), .to_ram_o(mem_to_ram)
  );

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock); // R4
  AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr != OFS_CTL && cfg_addr != OFS_EXT) |=>
      ($stable(smram_ctl) && $stable(smram_ext))); // R7
endmodule

// File: tb/tb_smram_lock_ctrl.sv
module tb_smram_lock_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic [19:0] mem_addr = 0;
  logic mem_smm = 0;
  logic mem_in_compat, mem_to_ram;
  logic [7:0] smram_ctl, smram_ext;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] ext_exp;
  logic [7:0] ctl_exp;

  smram_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_smm(mem_smm), .mem_in_compat(mem_in_compat), .mem_to_ram(mem_to_ram),
    .smram_ctl(smram_ctl), .smram_ext(smram_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic bit exp_ram(input logic [19:0] a, input bit smm, input logic [7:0] c);
    bit inw;
    inw = (a >= 20'ha0000) && (a < 20'hc0000);
    return inw && c[3] && ((smm && !c[5]) || c[6]);
  endfunction

  task automatic route_sweep(input logic [7:0] c);
    logic [19:0] pts [6];
    pts[0] = 20'h00000; pts[1] = 20'h9ffff; pts[2] = 20'ha0000;
    pts[3] = 20'hb1234; pts[4] = 20'hbffff; pts[5] = 20'hc0000;
    for (int i = 0; i < 6; i++) begin
      for (int s = 0; s < 2; s++) begin
        mem_addr = pts[i]; mem_smm = s[0];
        #1;
        chk("R8 window", {31'd0, mem_in_compat},
            {31'd0, (pts[i] >= 20'ha0000) && (pts[i] < 20'hc0000)});
        chk("R9 route", {31'd0, mem_to_ram}, {31'd0, exp_ram(pts[i], s[0], c)});
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h9d, d); chk("R1 ctl reset", d, 8'h02);
    rd(8'h9e, d); chk("R1 ext reset", d, 8'h38);
    chk("R1 ctl port", smram_ctl, 8'h02);

    // R2 and R10: unlocked main byte sweep (bit 4 kept clear)
    for (int w = 0; w < 256; w++) begin
      if (w[4] == 0) begin
        wr(8'h9d, w[7:0]);
        rd(8'h9d, d);
        chk("R2/R10 ctl unlocked", d, (w[7:0] & 8'h78) | 8'h02);
      end
    end

    // R3: unlocked extended sweep
    for (int w = 0; w < 256; w++) begin
      wr(8'h9e, w[7:0]);
      rd(8'h9e, d);
      ext_exp = (w[7:0] & 8'h87) | 8'h38;
      chk("R3 ext unlocked", d, ext_exp);
    end

    // R8, R9: routing over every open/close/enable combination
    for (int c = 0; c < 8; c++) begin
      ctl_exp = {1'b0, c[2], c[1], 1'b0, c[0], 3'b010};
      wr(8'h9d, ctl_exp);
      rd(8'h9d, d); chk("R9 setup", d, ctl_exp);
      route_sweep(ctl_exp);
    end

    // R7: foreign offsets
    ctl_exp = 8'h4a;
    wr(8'h9d, ctl_exp);
    wr(8'h9c, 8'hff);
    wr(8'h9f, 8'hff);
    rd(8'h9c, d); chk("R7 foreign read", d, 8'h00);
    rd(8'h9f, d); chk("R7 foreign read", d, 8'h00);
    rd(8'h9d, d); chk("R7 ctl untouched", d, ctl_exp);
    rd(8'h9e, d); chk("R7 ext untouched", d, ext_exp);

    // R4: engage lock
    wr(8'h9d, 8'h18);
    ctl_exp = 8'h1a;
    rd(8'h9d, d); chk("R4 lock set", d, ctl_exp);

    // R5, R4: locked main sweep, close only
    for (int w = 0; w < 256; w++) begin
      wr(8'h9d, w[7:0]);
      rd(8'h9d, d);
      chk("R5 ctl locked", d, 8'h1a | (w[7:0] & 8'h20));
      chk("R4 lock held", {31'd0, d[4]}, 32'd1);
      mem_addr = 20'ha0000; mem_smm = 1; #1;
      chk("R9 close under lock", {31'd0, mem_to_ram}, {31'd0, !w[5]});
    end

    // R6: locked extended sweep
    for (int w = 0; w < 256; w++) begin
      wr(8'h9e, w[7:0]);
      rd(8'h9e, d);
      chk("R6 ext locked", d, ext_exp);
    end

    // R1, R4: reset clears lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(8'h9d, d); chk("R1 ctl after reset", d, 8'h02);
    rd(8'h9e, d); chk("R1 ext after reset", d, 8'h38);
    wr(8'h9d, 8'h40);
    rd(8'h9d, d); chk("R4 unlocked after reset", d, 8'h42);
    wr(8'h9e, 8'h01);
    rd(8'h9e, d); chk("R3 ext after reset", d, 8'h39);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule